// File: doc/BRIEF.md
# Partitioned Lockable TLB Replacement

A small fully associative translation buffer that maps virtual page numbers to physical page numbers for a core running tasks of different criticality. Its entries are split into up to four index ranges, one per task, each described by a base index and a size. A lookup names its task, and it can only hit entries inside that task's range. A refill after a page walk also names its task. The refill may only overwrite an entry inside that range, and never one whose lock bit is set. So a busy task cannot push out the translations of a time-critical one, and pinned translations stay resident.

The victim is chosen in two steps. First comes the lowest-indexed invalid, unlocked entry of the range. If there is none, a binary pseudo-LRU tree over all entries is walked. At each node the walk steers away from subtrees that hold no eligible entry. When a range has no eligible entry at all, the refill is dropped and a reject flag is raised. Lookups are compared combinationally, and the result is registered for exactly one cycle of latency, whether or not the entry is locked.

Top module: `tlb_part_lock`

## Requirements
- R1: After reset, no entry is valid and no entry is locked. Partition p covers entries 4p to 4p+3, and the pseudo-LRU tree is all zero. rsp_valid, rsp_hit, fill_done and fill_reject are low.
- R2: A lookup presented in a cycle without a refill is answered in the next cycle with rsp_valid high. rsp_hit is high when a valid entry in the task's range holds lkp_vpn. On a hit, rsp_ppn and rsp_idx give that entry's translation and index, and the lowest such index wins.
- R3: A lookup whose task id is 4 or higher, or whose range is empty, is a miss. Entries outside the task's range [base, base+size) never hit.
- R4: A refill writes only an entry whose index lies in [base, base+size) of the refill's task id. It reports that index on fill_idx with fill_done, one cycle later.
- R5: A locked entry is never chosen as a refill victim while its lock bit is set. A hit on a locked entry is answered with the same one-cycle latency as any other hit.
- R6: When the refill's range has no unlocked entry (all locked, empty, or task id 4 or higher), nothing is written. fill_reject is high for one cycle instead of fill_done.
- R7: If the range holds an invalid unlocked entry, the victim is the lowest-indexed such entry.
- R8: Otherwise the victim comes from the 15-node tree: node 1 is the root, and node n has children 2n and 2n+1. Leaf 16+e stands for entry e. Starting at the root, a node bit of 1 selects the right child and 0 the left child. If the selected child's subtree holds no unlocked in-range entry, the other child is taken.
- R9: A hit answered with rsp_valid, and a completed refill, each update the tree along the path of the touched entry. Each node bit on the path is set to point to the opposite child from the one containing that entry.
- R10: When a lookup and a refill arrive in the same cycle, the refill is performed and the lookup is dropped: rsp_valid stays low in the next cycle and the tree is not touched by the lookup.
- R11: A partition write (cfg_part_we) sets the base and size of the selected partition. A lock write (cfg_lock_we) sets or clears one entry's lock bit. Both take effect for lookups and refills from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_pid | input | 3 | Task id of the lookup |
| lkp_vpn | input | 20 | Virtual page number to translate |
| fill_valid | input | 1 | Refill request |
| fill_pid | input | 3 | Task id of the refill |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| cfg_part_we | input | 1 | Partition register write |
| cfg_part_sel | input | 2 | Partition being written |
| cfg_base | input | 4 | New first entry index |
| cfg_size | input | 5 | New entry count (0 to 16) |
| cfg_lock_we | input | 1 | Lock bit write |
| cfg_lock_idx | input | 4 | Entry whose lock bit is written |
| cfg_lock_set | input | 1 | 1 locks, 0 unlocks |
| rsp_valid | output | 1 | Lookup answered this cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_idx | output | 4 | Index of the hit entry, 0 on miss |
| rsp_ppn | output | 20 | Physical page number of the hit, 0 on miss |
| fill_done | output | 1 | Refill written this cycle's previous request |
| fill_reject | output | 1 | Refill dropped for lack of an eligible entry |
| fill_idx | output | 4 | Entry written by the refill, 0 on reject |

## Verification
A corrupted tree bit cannot be observed by a lookup, only through fill_idx. It shows on the first refill to the affected range that finds no invalid entry, one cycle after that refill is issued. A wrong lock or range mask shows the same way, as a victim outside the range or on a locked entry, or as a spurious reject. A wrong stored tag, valid bit or range shows on the next lookup of that page, as a wrong rsp_hit or rsp_ppn one cycle after the request. The bench therefore runs long random mixes of refills, lookups, lock changes and range rewrites, so that the tree is read through many victim choices.

// File: rtl/tlb_part_lock.sv
module tlb_part_lock #(
  parameter int ENTRIES = 16,
  parameter int PARTS   = 4,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PID_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = IDX_W + 1,
  localparam int PSEL_W = (PARTS > 1) ? $clog2(PARTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [PID_W-1:0]  lkp_pid,
  input  logic [VPN_W-1:0]  lkp_vpn,
  input  logic              fill_valid,
  input  logic [PID_W-1:0]  fill_pid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              cfg_part_we,
  input  logic [PSEL_W-1:0] cfg_part_sel,
  input  logic [IDX_W-1:0]  cfg_base,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic              cfg_lock_we,
  input  logic [IDX_W-1:0]  cfg_lock_idx,
  input  logic              cfg_lock_set,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic              fill_done,
  output logic              fill_reject,
  output logic [IDX_W-1:0]  fill_idx
);

  localparam logic [PID_W:0] PARTS_L = (PID_W+1)'(PARTS);

  logic [ENTRIES-1:0] vld, lck;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   base_q [PARTS];
  logic [CNT_W-1:0]   size_q [PARTS];
  logic [ENTRIES-1:1] plru;

  logic [PARTS-1:0][ENTRIES-1:0] pm;
  logic [ENTRIES-1:0] lk_mask, fl_mask, match, cand, inv;
  logic [2*ENTRIES-1:1] sub;
  logic [IDX_W-1:0] hit_idx, inv_idx, lru_idx, victim;
  logic any_hit, can_fill, do_fill, do_touch;

  function automatic logic [IDX_W-1:0] lowest(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int e = ENTRIES-1; e >= 0; e--)
      if (v[e]) r = IDX_W'(e);
    return r;
  endfunction

  function automatic logic [ENTRIES-1:1] touch(input logic [ENTRIES-1:1] t,
                                               input logic [IDX_W-1:0]   e);
    int node;
    node = 1;
    for (int l = IDX_W-1; l >= 0; l--) begin
      t[node] = !e[l];
      node = 2*node + (e[l] ? 1 : 0);
    end
    return t;
  endfunction

  for (genvar p = 0; p < PARTS; p++) begin : g_part
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign pm[p][e] = (CNT_W'(e) >= {1'b0, base_q[p]}) &&
                        (CNT_W'(e) <  ({1'b0, base_q[p]} + size_q[p]));
    end
  end

  assign lk_mask = ({1'b0, lkp_pid}  < PARTS_L) ? pm[lkp_pid[PSEL_W-1:0]]  : '0;
  assign fl_mask = ({1'b0, fill_pid} < PARTS_L) ? pm[fill_pid[PSEL_W-1:0]] : '0;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match[e] = vld[e] && lk_mask[e] && (vpn_q[e] == lkp_vpn);
  end

  assign any_hit = |match;
  assign hit_idx = lowest(match);
  assign cand    = fl_mask & ~lck;
  assign inv     = cand & ~vld;
  assign inv_idx = lowest(inv);
  assign can_fill = |cand;

  always_comb begin
    sub = '0;
    for (int e = 0; e < ENTRIES; e++) sub[ENTRIES+e] = cand[e];
    for (int n = ENTRIES-1; n >= 1; n--) sub[n] = sub[2*n] | sub[2*n+1];
  end

  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < IDX_W; l++) begin
      if (plru[node] ? sub[2*node+1] : !sub[2*node]) node = 2*node + 1;
      else                                          node = 2*node;
    end
    lru_idx = IDX_W'(node - ENTRIES);
  end

  assign victim   = (|inv) ? inv_idx : lru_idx;
  assign do_fill  = fill_valid && can_fill;
  assign do_touch = lkp_valid && !fill_valid && any_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld         <= '0;
      lck         <= '0;
      plru        <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_idx     <= '0;
      rsp_ppn     <= '0;
      fill_done   <= 1'b0;
      fill_reject <= 1'b0;
      fill_idx    <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        vpn_q[e] <= '0;
        ppn_q[e] <= '0;
      end
      for (int p = 0; p < PARTS; p++) begin
        base_q[p] <= IDX_W'(p * (ENTRIES / PARTS));
        size_q[p] <= CNT_W'(ENTRIES / PARTS);
      end
    end else begin
      rsp_valid   <= lkp_valid && !fill_valid;
      rsp_hit     <= lkp_valid && !fill_valid && any_hit;
      rsp_idx     <= any_hit ? hit_idx : '0;
      rsp_ppn     <= any_hit ? ppn_q[hit_idx] : '0;
      fill_done   <= do_fill;
      fill_reject <= fill_valid && !can_fill;
      fill_idx    <= do_fill ? victim : '0;
      if (do_fill) begin
        vld[victim]   <= 1'b1;
        vpn_q[victim] <= fill_vpn;
        ppn_q[victim] <= fill_ppn;
        plru          <= touch(plru, victim);
      end else if (do_touch) begin
        plru <= touch(plru, hit_idx);
      end
      if (cfg_part_we) begin
        base_q[cfg_part_sel] <= cfg_base;
        size_q[cfg_part_sel] <= cfg_size;
      end
      if (cfg_lock_we) lck[cfg_lock_idx] <= cfg_lock_set;
    end
  end

endmodule

module tlb_part_lock_chk #(
  parameter int ENTRIES = 16,
  parameter int PARTS   = 4,
  parameter int PID_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lkp_valid,
  input logic [PID_W-1:0]   lkp_pid,
  input logic               fill_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               fill_done,
  input logic               fill_reject,
  input logic [IDX_W-1:0]   fill_idx,
  input logic [ENTRIES-1:0] fl_mask,
  input logic [ENTRIES-1:0] lck,
  input logic [ENTRIES-1:0] vld
);
  localparam logic [PID_W:0] PARTS_L = (PID_W+1)'(PARTS);

  logic [ENTRIES-1:0] fm_d, lck_d, vld_d;
  logic inv_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fm_d  <= '0;
      lck_d <= '0;
      vld_d <= '0;
      inv_d <= 1'b0;
    end else begin
      fm_d  <= fl_mask;
      lck_d <= lck;
      vld_d <= vld;
      inv_d <= |(fl_mask & ~lck & ~vld);
    end
  end

  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid && !fill_valid |=> rsp_valid);
  // R10
  fill_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !rsp_valid);
  // R3
  oor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid && ({1'b0, lkp_pid} >= PARTS_L) |=> !rsp_hit);
  // R4
  in_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> fm_d[fill_idx]);
  // R5
  no_locked_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> !lck_d[fill_idx]);
  // R6
  reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_done && fill_reject));
  // R6
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_reject |-> ((fm_d & ~lck_d) == '0));
  // R7
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done && inv_d |-> !vld_d[fill_idx]);
  // R2
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
endmodule

bind tlb_part_lock tlb_part_lock_chk #(
  .ENTRIES(ENTRIES), .PARTS(PARTS), .PID_W(PID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_pid(lkp_pid),
  .fill_valid(fill_valid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .fill_done(fill_done), .fill_reject(fill_reject), .fill_idx(fill_idx),
  .fl_mask(fl_mask), .lck(lck), .vld(vld)
);

// File: tb/tlb_part_lock_bench.sv
module tlb_part_lock_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        lkp_valid = 0, fill_valid = 0, cfg_part_we = 0, cfg_lock_we = 0, cfg_lock_set = 0;
  logic [2:0]  lkp_pid = 0, fill_pid = 0;
  logic [19:0] lkp_vpn = 0, fill_vpn = 0, fill_ppn = 0;
  logic [1:0]  cfg_part_sel = 0;
  logic [3:0]  cfg_base = 0, cfg_lock_idx = 0;
  logic [4:0]  cfg_size = 0;
  logic        rsp_valid, rsp_hit, fill_done, fill_reject;
  logic [3:0]  rsp_idx, fill_idx;
  logic [19:0] rsp_ppn;

  tlb_part_lock u_tlb_part_lock (.*);

  int errors = 0, checks = 0;

  logic [15:0] m_vld, m_lck;
  logic [19:0] m_vpn [16];
  logic [19:0] m_ppn [16];
  int          m_base [4];
  int          m_size [4];
  logic [15:1] m_tree;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pmask(input int pid);
    logic [15:0] m = '0;
    if (pid >= 0 && pid < 4)
      for (int e = 0; e < 16; e++)
        if (e >= m_base[pid] && e < m_base[pid] + m_size[pid]) m[e] = 1'b1;
    return m;
  endfunction

  function automatic bit has(input int node, input logic [15:0] c);
    int lvl = 0, span, lo;
    while ((node >> (lvl + 1)) != 0) lvl++;
    span = 16 >> lvl;
    lo = (node - (1 << lvl)) * span;
    for (int e = lo; e < lo + span; e++) if (c[e]) return 1;
    return 0;
  endfunction

  function automatic int mvictim(input logic [15:0] c);
    logic [15:0] iv = c & ~m_vld;
    int node = 1;
    for (int e = 0; e < 16; e++) if (iv[e]) return e;
    for (int l = 0; l < 4; l++) begin
      if (m_tree[node]) node = has(2*node+1, c) ? 2*node+1 : 2*node;
      else              node = has(2*node, c)   ? 2*node   : 2*node+1;
    end
    return node - 16;
  endfunction

  function automatic void mtouch(input int e);
    int node = 1;
    for (int l = 3; l >= 0; l--) begin
      int b = (e >> l) & 1;
      m_tree[node] = (b == 0);
      node = 2*node + b;
    end
  endfunction

  // One cycle: inputs already driven at a falling edge; compare at the next falling edge.
  task automatic tick();
    logic [15:0] lm, cand;
    int hidx = -1, vic = 0;
    bit ans, done;
    lm = pmask(int'(lkp_pid));
    for (int e = 15; e >= 0; e--)
      if (m_vld[e] && lm[e] && m_vpn[e] == lkp_vpn) hidx = e;
    ans  = lkp_valid && !fill_valid;
    cand = pmask(int'(fill_pid)) & ~m_lck;
    done = fill_valid && (cand != 0);
    if (done) vic = mvictim(cand);
    @(negedge clk);
    chk("R2 R10 rsp_valid", 32'(rsp_valid), 32'(ans));
    if (ans) begin
      chk("R2 R3 R5 rsp_hit", 32'(rsp_hit), 32'(hidx >= 0));
      if (hidx >= 0) begin
        chk("R2 rsp_idx", 32'(rsp_idx), 32'(hidx));
        chk("R2 rsp_ppn", 32'(rsp_ppn), 32'(m_ppn[hidx]));
      end
    end
    chk("R4 fill_done", 32'(fill_done), 32'(done));
    chk("R6 fill_reject", 32'(fill_reject), 32'(fill_valid && !done));
    if (done) chk("R4 R5 R7 R8 R9 fill_idx", 32'(fill_idx), 32'(vic));
    if (done) begin
      m_vld[vic] = 1'b1; m_vpn[vic] = fill_vpn; m_ppn[vic] = fill_ppn;
      mtouch(vic);
    end else if (ans && hidx >= 0) mtouch(hidx);
    if (cfg_part_we) begin
      m_base[cfg_part_sel] = int'(cfg_base);
      m_size[cfg_part_sel] = int'(cfg_size);
    end
    if (cfg_lock_we) m_lck[cfg_lock_idx] = cfg_lock_set;
    lkp_valid = 0; fill_valid = 0; cfg_part_we = 0; cfg_lock_we = 0;
  endtask

  task automatic lookup(input int pid, input int vpn);
    lkp_valid = 1; lkp_pid = 3'(pid); lkp_vpn = 20'(vpn); tick();
  endtask
  task automatic refill(input int pid, input int vpn, input int ppn);
    fill_valid = 1; fill_pid = 3'(pid); fill_vpn = 20'(vpn); fill_ppn = 20'(ppn); tick();
  endtask
  task automatic lockw(input int idx, input bit set);
    cfg_lock_we = 1; cfg_lock_idx = 4'(idx); cfg_lock_set = set; tick();
  endtask
  task automatic partw(input int p, input int b, input int s);
    cfg_part_we = 1; cfg_part_sel = 2'(p); cfg_base = 4'(b); cfg_size = 5'(s); tick();
  endtask

  initial begin
    m_vld = '0; m_lck = '0; m_tree = '0;
    for (int e = 0; e < 16; e++) begin m_vpn[e] = '0; m_ppn[e] = '0; end
    for (int p = 0; p < 4; p++) begin m_base[p] = 4*p; m_size[p] = 4; end
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 rsp_hit", 32'(rsp_hit), 0);
    chk("R1 fill_done", 32'(fill_done), 0);
    chk("R1 fill_reject", 32'(fill_reject), 0);
    lookup(0, 7);                                   // R2 miss on empty buffer
    for (int i = 0; i < 4; i++) refill(0, 16 + i, 100 + i);  // R7 invalid first
    for (int i = 0; i < 4; i++) lookup(0, 16 + i);  // R2 hits
    lookup(1, 17);                                  // R3 other partition misses
    lookup(5, 17);                                  // R3 id out of range
    refill(0, 30, 200);                             // R8 tree choice
    lookup(0, 18);                                  // R9 hit touches tree
    refill(0, 31, 201);
    lockw(0, 1);                                    // R11 lock write
    lookup(0, 30);                                  // R5 locked hit latency
    for (int i = 4; i < 8; i++) lockw(i, 1);
    refill(1, 40, 300);                             // R6 all locked
    lockw(5, 0);
    refill(1, 41, 301);                             // R5 only unlocked entry
    fill_valid = 1; fill_pid = 2; fill_vpn = 50; fill_ppn = 400;
    lkp_valid = 1; lkp_pid = 0; lkp_vpn = 16; tick(); // R10 refill wins
    partw(3, 15, 0);                                // R11 empty partition
    refill(3, 60, 500);                             // R6 empty range
    lookup(3, 60);                                  // R3 empty range misses
    partw(3, 12, 4);
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] fm;
      bit dup = 0;
      lkp_valid = ($urandom % 100) < 60;
      lkp_pid = 3'($urandom % 6);
      lkp_vpn = 20'($urandom % 24);
      fill_valid = ($urandom % 100) < 35;
      fill_pid = 3'($urandom % 5);
      fill_vpn = 20'($urandom % 24);
      fill_ppn = 20'($urandom);
      fm = pmask(int'(fill_pid));
      for (int e = 0; e < 16; e++) if (fm[e] && m_vld[e] && m_vpn[e] == fill_vpn) dup = 1;
      if (dup) fill_valid = 0;
      cfg_lock_we = ($urandom % 100) < 8;
      cfg_lock_idx = 4'($urandom % 16);
      cfg_lock_set = ($urandom % 3) != 0;
      cfg_part_we = ($urandom % 100) < 3;
      cfg_part_sel = 2'($urandom % 4);
      cfg_base = 4'($urandom % 16);
      cfg_size = 5'($urandom % 9);
      tick();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule